// File: doc/BRIEF.md
# Prescaled Two-Channel PWM with Write-Pending Flags

This block is a register-mapped pulse-width modulator with two independent channels on a plain 32-bit write/read bus. Each channel divides the input clock by a programmable prescaler. The divided ticks drive a period counter. The output is active while the period count is below a duty threshold. Software writes the prescaler, period, duty and control values one at a time.

Each write lands first in a bus-side copy of the register and raises a pending flag. The value then moves into the counting logic after a short fixed delay, and the flag drops. Software polls a shared status word until the flag clears before it writes the next value. When autoload is selected on a running channel, new period and duty values wait for the end of the current period. This lets a waveform change without a glitch.

Disabling a channel either cuts the output to its idle level at once or lets the current period run out first, depending on a control bit. The idle level is the inactive level, which follows the invert bit.

Top module: `prescaled_pwm`

## Requirements
- R1: After reset every register, every pending flag and both outputs read zero.
- R2: Channel n's registers sit at byte address 16n: control at +0x0, prescaler at +0x4, period at +0x8 and duty at +0xC. The prescaler reads back 10 bits and the period and duty read back 12 bits. Control reads back bits 3:0: bit0 enable, bit1 invert, bit2 autoload, bit3 stop-immediately. Bits 4 and 5 read as zero.
- R3: The status word at 0x40 holds channel n's flags at bits 8n to 8n+3, in the order control, prescaler, period, duty. A write sets the matching flag from the next cycle on. Every other status bit is zero.
- R4: The new value takes effect, and its flag clears, on the second clock edge after the write edge. This holds unless R8 defers it.
- R5: One output period lasts (prescaler+1)*(period+1) clocks. The output is active for duty*(prescaler+1) clocks, starting at the period start.
- R6: A duty of period+1 or more keeps the output active for the whole period. A duty of 0 keeps it inactive for the whole period.
- R7: The invert bit inverts the output. A stopped channel drives its idle level, which equals the invert bit.
- R8: With autoload set on a running channel, a new period or duty value, and its flag, wait for the next period wrap. At that wrap the value takes effect and the flag clears.
- R9: If a control write clears enable with stop-immediately set, the output goes idle at commit. If stop-immediately is clear, the current period completes first.
- R10: Control bit5 written as 1 restarts both counters when the control value commits. Control bit4 restarts only the prescaler count.
- R11: The address slots for channels 2 and 3 (0x20 to 0x3F) read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
The bench aligns the counters with the restart bit and then compares exact output patterns. An off-by-one in the prescaler or the period compare, or a restart that leaves one counter running, therefore moves an edge by at least one clock. It probes the duty boundary at period+1 and at zero, where a strict-versus-inclusive compare error shows as a single-tick glitch. In the autoload case it checks the pending flag and the output just before the wrap, which catches a design that commits too early. Both disable modes are timed to the exact cycle, so a stop that does not wait, or a stop that ignores the immediate bit, fails.

// File: rtl/prescaled_pwm.sv
`timescale 1ns/1ps
module prescaled_pwm #(
  parameter int NCH   = 2,
  parameter int PSC_W = 10,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NCH-1:0]   pwm_out
);
  localparam int EN = 0, INV = 1, AL = 2, STOP = 3;

  logic [31:0]        rd_word [NCH];
  logic [4*NCH-1:0]   pend_all;
  logic [NCH-1:0]     run_all;

  wire unused_ok = ^{bus_addr[1:0], bus_wdata[31:PER_W]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [3:0]       ctl_w, ctl_a, pend, armed;
    logic [1:0]       ld_w;
    logic [PSC_W-1:0] psc_w, psc_a, psc_cnt;
    logic [PER_W-1:0] per_w, per_a, duty_w, duty_a, per_cnt;
    logic             run;

    wire [3:0] we = (bus_wr && !bus_addr[6] && bus_addr[5:4] == 2'(g))
                    ? (4'(1) << bus_addr[3:2]) : 4'b0;
    wire tick = run && psc_cnt >= psc_a;
    wire wrap = tick && per_cnt >= per_a;
    wire hold = run && ctl_a[AL] && !wrap;
    wire [3:0] go = pend & armed & {~hold, ~hold, 2'b11};
    wire halt = go[0] && !ctl_w[EN] && ctl_w[STOP];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_w <= '0; ctl_a <= '0; ld_w <= '0;
        psc_w <= '0; psc_a <= '0; per_w <= '0; per_a <= '0;
        duty_w <= '0; duty_a <= '0;
        pend <= '0; armed <= '0; run <= 1'b0;
        psc_cnt <= '0; per_cnt <= '0;
      end else begin
        pend  <= we | (pend & ~go);
        armed <= pend & ~we & ~go;

        if (we[0]) begin
          ctl_w <= bus_wdata[3:0];
          ld_w  <= bus_wdata[5:4];
        end
        if (we[1]) psc_w  <= bus_wdata[PSC_W-1:0];
        if (we[2]) per_w  <= bus_wdata[PER_W-1:0];
        if (we[3]) duty_w <= bus_wdata[PER_W-1:0];

        if (go[0]) ctl_a  <= ctl_w;
        if (go[1]) psc_a  <= psc_w;
        if (go[2]) per_a  <= per_w;
        if (go[3]) duty_a <= duty_w;

        if (go[0] && ctl_w[EN])
          run <= 1'b1;
        else if (halt || (wrap && !ctl_a[EN]))
          run <= 1'b0;

        if (halt || (go[0] && ld_w[1]) || !run) begin
          psc_cnt <= '0;
          per_cnt <= '0;
        end else if (go[0] && ld_w[0]) begin
          psc_cnt <= '0;
        end else if (tick) begin
          psc_cnt <= '0;
          per_cnt <= wrap ? '0 : per_cnt + 1'b1;
        end else begin
          psc_cnt <= psc_cnt + 1'b1;
        end
      end
    end

    assign pwm_out[g] = run ? ((per_cnt < duty_a) ^ ctl_a[INV]) : ctl_a[INV];
    assign rd_word[g] = (bus_addr[3:2] == 2'd0) ? 32'(ctl_w)  :
                        (bus_addr[3:2] == 2'd1) ? 32'(psc_w)  :
                        (bus_addr[3:2] == 2'd2) ? 32'(per_w)  : 32'(duty_w);
    assign pend_all[4*g +: 4] = pend;
    assign run_all[g] = run;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[6:2] == 5'b10000) begin
      for (int i = 0; i < NCH; i++) bus_rdata[8*i +: 4] = pend_all[4*i +: 4];
    end else if (!bus_addr[6]) begin
      for (int i = 0; i < NCH; i++)
        if (bus_addr[5:4] == 2'(i)) bus_rdata = rd_word[i];
    end
  end
endmodule

// File: rtl/prescaled_pwm_chk.sv
`timescale 1ns/1ps
module prescaled_pwm_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [6:0]       bus_addr,
  input logic [4*NCH-1:0] pend_all
);
  wire wr_ctl0 = bus_wr && bus_addr == 7'h00;
  wire wr_psc1 = bus_wr && bus_addr == 7'h14;
  wire wr_hole = bus_wr && bus_addr[6:5] == 2'b01;

  assert_flag_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[6:4] == 3'b000 |=> pend_all[$past(bus_addr[3:2])]);

  assert_one_new_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_all) <= $countones($past(pend_all)) + 1);

  assert_ctl_flag_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_all[0] && $past(pend_all[0]) && !wr_ctl0 && !$past(wr_ctl0) |=> !pend_all[0]);

  assert_psc_flag_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_all[5] && $past(pend_all[5]) && !wr_psc1 && !$past(wr_psc1) |=> !pend_all[5]);

  assert_hole_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hole |=> $countones(pend_all) <= $countones($past(pend_all)));
endmodule

bind prescaled_pwm prescaled_pwm_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .pend_all(pend_all)
);

// File: tb/prescaled_pwm_test.sv
`timescale 1ns/1ps
module prescaled_pwm_test;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [1:0]  pwm_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  prescaled_pwm uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  localparam logic [71:0] VEC [10] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_03FF},
    {8'h08, 32'h0000_FFFF, 32'h0000_0FFF},
    {8'h0C, 32'h0000_1234, 32'h0000_0234},
    {8'h00, 32'h0000_003E, 32'h0000_000E},
    {8'h14, 32'h0000_0155, 32'h0000_0155},
    {8'h18, 32'h0000_0ABC, 32'h0000_0ABC},
    {8'h1C, 32'h0000_0007, 32'h0000_0007},
    {8'h10, 32'h0000_0002, 32'h0000_0002},
    {8'h24, 32'h0000_03FF, 32'h0000_0000},
    {8'h3C, 32'h0000_0FFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic cnt_hi(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      h += int'(pwm_out[ch]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] act, exp;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'h40, v); chk("R1 status", v, 0);
    rd(7'h00, v); chk("R1 ctrl", v, 0);
    rd(7'h18, v); chk("R1 period", v, 0);
    chk("R1 outputs", 32'(pwm_out), 0);

    // R2 and R11 readback table
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], v);
      chk(VEC[i][71:64] >= 8'h20 ? "R11 hole readback" : "R2 readback", v, VEC[i][31:0]);
      repeat (3) @(negedge clk);
    end
    rd(7'h40, v); chk("R3 flags settled", v, 0);
    chk("R7 idle follows invert", 32'(pwm_out), 32'h3);

    // R3 and R4 flag timing
    wr(7'h08, 4); wr(7'h1C, 3);
    rd(7'h40, v); chk("R3 two flags", v, 32'h0804);
    @(negedge clk);
    rd(7'h40, v); chk("R4 first clears", v, 32'h0800);
    @(negedge clk);
    rd(7'h40, v); chk("R4 second clears", v, 0);

    // R5 exact pattern: presc 2, period 3, duty 2
    wr(7'h04, 2); wr(7'h08, 3); wr(7'h0C, 2);
    repeat (3) @(negedge clk);
    wr(7'h00, 32'h21);
    @(negedge clk); @(negedge clk);
    act = '0; exp = '0;
    for (int k = 0; k < 14; k++) begin
      act[k] = pwm_out[0];
      exp[k] = (k % 12) < 6;
      if (k < 13) @(negedge clk);
    end
    chk("R5 pattern", 32'(act), 32'(exp));

    // R5 and R6 duty sweep: presc 1, period 4
    wr(7'h04, 1); wr(7'h08, 4); wr(7'h0C, 2);
    repeat (3) @(negedge clk);
    wr(7'h00, 32'h21);
    @(negedge clk); @(negedge clk);
    cnt_hi(0, 20, h); chk("R5 duty 2", h, 8);
    wr(7'h0C, 7); repeat (3) @(negedge clk);
    cnt_hi(0, 20, h); chk("R6 duty above period", h, 20);
    wr(7'h0C, 5); repeat (3) @(negedge clk);
    cnt_hi(0, 20, h); chk("R6 duty equal period plus one", h, 20);
    wr(7'h0C, 0); repeat (3) @(negedge clk);
    cnt_hi(0, 20, h); chk("R6 duty zero", h, 0);
    wr(7'h0C, 4); repeat (3) @(negedge clk);
    cnt_hi(0, 20, h); chk("R5 duty 4", h, 16);
    wr(7'h0C, 2); wr(7'h00, 32'h03); repeat (3) @(negedge clk);
    cnt_hi(0, 20, h); chk("R7 inverted", h, 12);

    // R2 second channel
    wr(7'h14, 0); wr(7'h18, 3); wr(7'h1C, 1); wr(7'h10, 32'h21);
    repeat (3) @(negedge clk);
    cnt_hi(1, 20, h); chk("R2 channel 1 output", h, 5);

    // R10 prescaler-only restart
    wr(7'h04, 3); wr(7'h08, 1); wr(7'h0C, 1);
    repeat (3) @(negedge clk);
    wr(7'h00, 32'h21);
    @(negedge clk); @(negedge clk);
    act = '0; exp = '0;
    act[0] = pwm_out[0];
    wr(7'h00, 32'h11);
    act[1] = pwm_out[0];
    for (int k = 2; k < 13; k++) begin
      @(negedge clk);
      act[k] = pwm_out[0];
    end
    for (int k = 0; k < 13; k++) exp[k] = (k < 7) || (k >= 11);
    chk("R10 prescaler restart", 32'(act), 32'(exp));

    // R8 autoload
    wr(7'h04, 0); wr(7'h08, 9); wr(7'h0C, 3);
    repeat (3) @(negedge clk);
    wr(7'h00, 32'h25);
    @(negedge clk); @(negedge clk); @(negedge clk);
    wr(7'h0C, 7);
    rd(7'h40, v); chk("R8 duty flag set", v & 32'h8, 32'h8);
    repeat (4) @(negedge clk);
    chk("R8 old duty kept", 32'(pwm_out[0]), 0);
    repeat (2) @(negedge clk);
    rd(7'h40, v); chk("R8 flag held before wrap", v & 32'h8, 32'h8);
    @(negedge clk); @(negedge clk);
    rd(7'h40, v); chk("R8 flag clears at wrap", v, 0);
    cnt_hi(0, 10, h); chk("R8 new duty", h, 7);

    // R9 stop immediately
    wr(7'h00, 32'h21); repeat (3) @(negedge clk);
    wr(7'h0C, 15); repeat (3) @(negedge clk);
    chk("R6 full duty", 32'(pwm_out[0]), 1);
    wr(7'h00, 32'h08);
    chk("R9 before commit", 32'(pwm_out[0]), 1);
    @(negedge clk);
    chk("R9 one edge after", 32'(pwm_out[0]), 1);
    @(negedge clk);
    chk("R9 idle at commit", 32'(pwm_out[0]), 0);
    cnt_hi(0, 20, h); chk("R9 stays idle", h, 0);

    // R9 stop at period end
    wr(7'h00, 32'h21);
    @(negedge clk); @(negedge clk); @(negedge clk);
    wr(7'h00, 32'h00);
    repeat (7) @(negedge clk);
    chk("R9 period completes", 32'(pwm_out[0]), 1);
    @(negedge clk);
    chk("R9 idle after wrap", 32'(pwm_out[0]), 0);

    // R7 idle level with invert
    wr(7'h00, 32'h0A);
    @(negedge clk); @(negedge clk);
    cnt_hi(0, 10, h); chk("R7 inverted idle", h, 10);

    // R11 unimplemented slot
    wr(7'h24, 5);
    rd(7'h40, v); chk("R11 no flag", v, 0);
    rd(7'h20, v); chk("R11 reads zero", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule